// File: doc/BRIEF.md
# Tri-state edge phase-frequency detector

This block compares a reference signal against an oscillator-derived feedback signal and tells a loop filter which way to steer the oscillator. Both inputs may be asynchronous to the system clock. Each one is brought into the clock domain by a synchronizer chain, and a rising edge is recognised when the synchronized value changes from 0 to 1 between two consecutive clocks. The block acts on rising edges only, so the duty cycle of either input does not affect the outputs.

The correction output has three states, carried as a drive value plus an output enable:
- **Charge:** the block drives high after a reference edge and holds this until a feedback edge arrives.
- **Discharge:** the block drives low after a feedback edge and holds this until a reference edge arrives.
- **Float:** the block does not drive the pin.

With aligned inputs of equal frequency the pin floats, so the loop settles at zero phase difference. When the feedback is slower than the reference, the pin is driven high most of the time. When the feedback is faster, it is driven low most of the time. This makes the block a frequency detector as well as a phase detector. A lock pulse output is high exactly while the correction pin floats.

Top module: `tristate_pfd`

## Requirements
- R1: A synchronous active-high reset puts the block in the floating state: corr_oe = 0, corr_val = 0 and lock_pulse = 1.
- R2: In the floating state, a reference rising edge with no feedback rising edge in the same cycle makes the block drive high (corr_oe = 1, corr_val = 1).
- R3: While driving high, the block holds that output until the next feedback rising edge, which returns it to floating.
- R4: In the floating state, a feedback rising edge with no reference rising edge in the same cycle makes the block drive low (corr_oe = 1, corr_val = 0). With no reference edges at all, the output stays driven low continuously.
- R5: While driving low, the block holds that output until the next reference rising edge, which returns it to floating.
- R6: Reference and feedback rising edges recognised in the same clock cycle cancel, and the block returns to, or stays in, the floating state.
- R7: lock_pulse equals the inverse of corr_oe in every cycle.
- R8: Falling edges and the length of the high time of either input do not affect the outputs.
- R9: A further edge of the same input while that input's request is active is absorbed. For example, an extra reference edge while driving high keeps the output high.
- R10: An input level change made before clock edge k is reflected on the outputs after clock edge k+2, which is three registers deep.
- R11: corr_val is 0 whenever corr_oe is 0.
- R12: When the feedback runs slower than the reference, the block spends more cycles driving high than driving low. When the feedback runs faster, it spends more cycles driving low than driving high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Reference signal, asynchronous |
| fb_in | input | 1 | Feedback signal from the oscillator path, asynchronous |
| corr_val | output | 1 | Drive value of the correction pin (1 = charge, 0 = discharge) |
| corr_oe | output | 1 | Correction pin enable (0 = high impedance) |
| lock_pulse | output | 1 | High while the correction pin floats |

## Verification
A wrong state in the memory shows as a stuck enable or value on the correction pin. The bench's reference model sees it on the first clock after the offending edge is recognised. A misrouted or lost edge shifts the pin's response by a cycle or drops it entirely, so timing and ordering errors are caught within three clocks of the stimulus. A broken cancel or absorb rule shows up as a spurious request that persists until the opposite input next rises. Long periodic runs then turn this into a large mismatch in the counts of charge and discharge cycles.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    // Request memory state: floating, charge request, discharge request
    typedef enum logic [1:0] {
        PFD_IDLE      = 2'b00,
        PFD_CHARGE    = 2'b01,
        PFD_DISCHARGE = 2'b10
    } pfd_state_e;

    // Rising edges recognised in one clock cycle
    typedef struct packed {
        logic rise_ref;
        logic rise_fb;
    } pfd_edges_t;

    // Output pin bundle
    typedef struct packed {
        logic oe;
        logic val;
        logic lock;
    } pfd_pins_t;

    localparam int PFD_NUM_INPUTS = 2;
    localparam int PFD_IDX_REF    = 0;
    localparam int PFD_IDX_FB     = 1;

    // Next request state from current state and this cycle's edges
    function automatic pfd_state_e pfd_next(input pfd_state_e cur, input pfd_edges_t e);
        pfd_state_e nxt;
        nxt = cur;
        case (cur)
            PFD_IDLE: begin
                if (e.rise_ref && !e.rise_fb)      nxt = PFD_CHARGE;
                else if (e.rise_fb && !e.rise_ref) nxt = PFD_DISCHARGE;
                else                               nxt = PFD_IDLE;
            end
            PFD_CHARGE:    nxt = e.rise_fb  ? PFD_IDLE : PFD_CHARGE;
            PFD_DISCHARGE: nxt = e.rise_ref ? PFD_IDLE : PFD_DISCHARGE;
            default:       nxt = PFD_IDLE;
        endcase
        return nxt;
    endfunction

    // Pin values for a state
    function automatic pfd_pins_t pfd_pins_of(input pfd_state_e s);
        pfd_pins_t p;
        p.oe   = (s == PFD_CHARGE) || (s == PFD_DISCHARGE);
        p.val  = (s == PFD_CHARGE);
        p.lock = !p.oe;
        return p;
    endfunction

endpackage

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] chain;
    logic              held;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            held  <= 1'b0;
        end else begin
            chain[0] <= async_in;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
            held <= chain[LAST];
        end
    end

    assign rise = chain[LAST] & ~held;
endmodule

// File: rtl/pfd_state_mem.sv
module pfd_state_mem
    import pfd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  pfd_edges_t edges,
    output pfd_state_e state
);
    always_ff @(posedge clk) begin
        if (rst) state <= PFD_IDLE;
        else     state <= pfd_next(state, edges);
    end
endmodule

// File: rtl/pfd_pin_drive.sv
module pfd_pin_drive
    import pfd_pkg::*;
(
    input  pfd_state_e state,
    output pfd_pins_t  pins
);
    always_comb pins = pfd_pins_of(state);
endmodule

// File: rtl/tristate_pfd.sv
module tristate_pfd
    import pfd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_in,
    input  logic fb_in,
    output logic corr_val,
    output logic corr_oe,
    output logic lock_pulse
);
    logic [PFD_NUM_INPUTS-1:0] raw_in;
    logic [PFD_NUM_INPUTS-1:0] rise_vec;
    pfd_edges_t                edges;
    pfd_state_e                st;
    pfd_pins_t                 pins;

    assign raw_in[PFD_IDX_REF] = ref_in;
    assign raw_in[PFD_IDX_FB]  = fb_in;

    for (genvar g = 0; g < PFD_NUM_INPUTS; g++) begin : g_sync
        pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk      (clk),
            .rst      (rst),
            .async_in (raw_in[g]),
            .rise     (rise_vec[g])
        );
    end

    assign edges.rise_ref = rise_vec[PFD_IDX_REF];
    assign edges.rise_fb  = rise_vec[PFD_IDX_FB];

    pfd_state_mem u_mem (
        .clk   (clk),
        .rst   (rst),
        .edges (edges),
        .state (st)
    );

    pfd_pin_drive u_drive (
        .state (st),
        .pins  (pins)
    );

    assign corr_oe    = pins.oe;
    assign corr_val   = pins.val;
    assign lock_pulse = pins.lock;
endmodule

// File: rtl/tristate_pfd_chk.sv
module tristate_pfd_chk
    import pfd_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input pfd_edges_t edges,
    input pfd_state_e st,
    input logic       corr_val,
    input logic       corr_oe,
    input logic       lock_pulse
);
    // R1
    reset_float_chk: assert property (@(posedge clk) $past(rst) |-> (!corr_oe && lock_pulse));

    // R7
    lock_inverse_chk: assert property (@(posedge clk) disable iff (rst) lock_pulse == !corr_oe);

    // R11
    float_val_chk: assert property (@(posedge clk) disable iff (rst) !corr_oe |-> !corr_val);

    // R2
    idle_ref_chk: assert property (@(posedge clk) disable iff (rst)
        (st == PFD_IDLE && edges.rise_ref && !edges.rise_fb) |=> (corr_oe && corr_val));

    // R4
    idle_fb_chk: assert property (@(posedge clk) disable iff (rst)
        (st == PFD_IDLE && edges.rise_fb && !edges.rise_ref) |=> (corr_oe && !corr_val));

    // R3
    charge_end_chk: assert property (@(posedge clk) disable iff (rst)
        (st == PFD_CHARGE && edges.rise_fb) |=> !corr_oe);

    // R5
    discharge_end_chk: assert property (@(posedge clk) disable iff (rst)
        (st == PFD_DISCHARGE && edges.rise_ref) |=> !corr_oe);

    // R6
    cancel_chk: assert property (@(posedge clk) disable iff (rst)
        (st == PFD_IDLE && edges.rise_ref && edges.rise_fb) |=> !corr_oe);

    // R9
    charge_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st == PFD_CHARGE && !edges.rise_fb) |=> (corr_oe && corr_val));

    // R9
    discharge_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st == PFD_DISCHARGE && !edges.rise_ref) |=> (corr_oe && !corr_val));
endmodule

bind tristate_pfd tristate_pfd_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .edges      (edges),
    .st         (st),
    .corr_val   (corr_val),
    .corr_oe    (corr_oe),
    .lock_pulse (lock_pulse)
);

// File: tb/tristate_pfd_tb.sv
`timescale 1ns/1ps
module tristate_pfd_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_in = 1'b0;
    logic fb_in = 1'b0;
    logic corr_val, corr_oe, lock_pulse;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    tristate_pfd u_dut (
        .clk(clk), .rst(rst), .ref_in(ref_in), .fb_in(fb_in),
        .corr_val(corr_val), .corr_oe(corr_oe), .lock_pulse(lock_pulse)
    );

    // Behavioural model: 0 float, 1 charge, 2 discharge
    int m_state = 0;
    bit rq[$] = '{0, 0, 0};
    bit fq[$] = '{0, 0, 0};

    always @(posedge clk) begin
        bit re, fe;
        if (rst) begin
            m_state = 0;
            rq = '{0, 0, 0};
            fq = '{0, 0, 0};
        end else begin
            // value seen two samples ago rising vs three samples ago
            re = rq[1] && !rq[2];
            fe = fq[1] && !fq[2];
            if (m_state == 0) begin
                if (re && !fe) m_state = 1;
                else if (fe && !re) m_state = 2;
            end else if (m_state == 1) begin
                if (fe) m_state = 0;
            end else begin
                if (re) m_state = 0;
            end
            rq.push_front(ref_in); void'(rq.pop_back());
            fq.push_front(fb_in);  void'(fq.pop_back());
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // R10: cycle-accurate comparison with the model on every clock
    always @(negedge clk) begin
        if (!done) begin
            check("R10 model corr_oe", corr_oe, (m_state != 0));
            check("R10 model corr_val", corr_val, (m_state == 1));
            check("R7 model lock_pulse", lock_pulse, (m_state == 0));
        end
    end

    task automatic expect_pins(input string tag, input int oe, input int val);
        check({tag, " oe"}, corr_oe, oe);
        check({tag, " val"}, corr_val, val);
        check({tag, " lock"}, lock_pulse, !oe);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    int chg_cnt, dis_cnt;

    task automatic run_periodic(input int rper, input int fper, input int cycles);
        chg_cnt = 0; dis_cnt = 0;
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            if (rper > 0) ref_in = ((c % rper) < rper / 2);
            fb_in = ((c % fper) < fper / 2);
            if (corr_oe && corr_val)  chg_cnt++;
            if (corr_oe && !corr_val) dis_cnt++;
        end
        @(negedge clk); ref_in = 0; fb_in = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1
        expect_pins("R1 reset", 0, 0);
        rst = 0;
        wait_cyc(4);
        expect_pins("R1 after reset", 0, 0);

        // R2 / R10: reference edge, output moves after third clock
        ref_in = 1;
        wait_cyc(2);
        expect_pins("R10 not yet", 0, 0);
        ref_in = 0;
        wait_cyc(1);
        expect_pins("R2 charge", 1, 1);

        // R3 hold, R9 extra reference edge absorbed
        wait_cyc(10);
        expect_pins("R3 hold", 1, 1);
        ref_in = 1; wait_cyc(2); ref_in = 0;
        wait_cyc(6);
        expect_pins("R9 absorbed", 1, 1);

        // R3 feedback edge ends charge
        fb_in = 1; wait_cyc(3);
        expect_pins("R3 release", 0, 0);
        fb_in = 0;
        wait_cyc(3);
        // R4 feedback edge from float
        fb_in = 1; wait_cyc(3);
        expect_pins("R4 discharge", 1, 0);
        // R8 falling feedback ignored
        fb_in = 0; wait_cyc(6);
        expect_pins("R8 falling ignored", 1, 0);
        // R5 reference edge ends discharge
        ref_in = 1; wait_cyc(3);
        expect_pins("R5 release", 0, 0);
        ref_in = 0; wait_cyc(4);

        // R6 simultaneous edges cancel, R11 value low while floating
        ref_in = 1; fb_in = 1; wait_cyc(3);
        expect_pins("R6 cancel", 0, 0);
        check("R11 val low", corr_val, 0);
        ref_in = 0; fb_in = 0; wait_cyc(4);

        // R8 long high time vs single-cycle pulse
        ref_in = 1; wait_cyc(20);
        expect_pins("R8 long high", 1, 1);
        ref_in = 0; wait_cyc(5);
        expect_pins("R8 after fall", 1, 1);
        fb_in = 1; @(negedge clk); fb_in = 0; wait_cyc(2);
        expect_pins("R8 short pulse", 0, 0);
        wait_cyc(3);

        // R1 reset during an active request
        ref_in = 1; wait_cyc(3); ref_in = 0;
        expect_pins("R1 pre", 1, 1);
        rst = 1; wait_cyc(1);
        expect_pins("R1 mid-run", 0, 0);
        rst = 0; wait_cyc(4);

        // R4 no reference: constant discharge
        run_periodic(0, 12, 240);
        check("R4 fb only no charge", chg_cnt, 0);
        check("R4 fb only discharge", (dis_cnt >= 230), 1);
        wait_cyc(2);
        ref_in = 1; wait_cyc(3); ref_in = 0; wait_cyc(4);

        // R12 slower feedback: mostly high
        run_periodic(10, 14, 600);
        check("R12 slow fb mostly high", (chg_cnt > dis_cnt), 1);
        // R12 faster feedback: mostly low
        run_periodic(14, 10, 600);
        check("R12 fast fb mostly low", (dis_cnt > chg_cnt), 1);

        // equal frequency, aligned: stays floating
        wait_cyc(3);
        if (corr_oe) begin
            if (corr_val) begin fb_in = 1; wait_cyc(3); fb_in = 0; end
            else begin ref_in = 1; wait_cyc(3); ref_in = 0; end
        end
        wait_cyc(4);
        run_periodic(8, 8, 200);
        check("R6 aligned no charge", chg_cnt, 0);
        check("R6 aligned no discharge", dis_cnt, 0);

        wait_cyc(4);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule